// File: doc/BRIEF.md
# Parallel Port Pattern-Match Interrupt Unit

This block holds the interrupt logic of one eight-line parallel port when that port runs in bit-control mode. A host writes control bytes one at a time. The block decodes those bytes as mode words, interrupt control words and enable words. Some words say that the following byte carries data. After such a word, the next control byte is stored as a monitor mask or as a direction map, and it is not decoded as a command.

The block passes the port lines through a two-stage synchronizer. It then tests them against a programmable pattern. The lines under test are the ones whose mask bit is 0. The active level is high or low. The lines are combined with AND or with OR. A pending interrupt is latched when the pattern condition goes from false to true. The interrupt request is the pending flag gated by the enable. Host reads return the synchronized input lines on bits set as inputs and the output register on bits set as outputs.

Top module: `port_match_irq`

## Requirements
- R1: After reset, `irq` is 0, the enable is clear, the pending flag is clear, no data byte is expected, the mask is 8'hFF, the mode is input (`port_oe` = 8'h00), the direction map is 8'hFF and the output register is 8'h00.
- R2: A control byte whose bits [3:0] are 4'b0111 is an interrupt control word. Its bit 7 sets the enable (1) or clears it (0), and `irq` is high only while the enable is set and an interrupt is pending.
- R3: When an interrupt is already pending and the enable becomes set, `irq` is high from the clock edge that takes that write.
- R4: Bit 6 of the interrupt control word selects the combining function. With 1 (AND), every monitored line must be at the active level; when no line is monitored, the AND condition is never true. With 0 (OR), one monitored line at the active level is enough.
- R5: Bit 5 of the interrupt control word selects the active level: 1 for high, 0 for low.
- R6: An interrupt control word with bit 4 set clears the pending flag, in any mode. The next control byte is then stored as the mask, even when that byte looks like a command. A mask bit of 0 means the line is monitored.
- R7: A pending interrupt is set on the clock edge at which the match condition, computed from the synchronized lines, goes from false to true. A port line change therefore reaches `irq` on the third rising edge after it.
- R8: A mode word has bits [3:0] = 4'b1111 and the mode in bits [7:6]: 00 output, 01 input, 10 bidirectional, 11 bit control. In bit-control mode the next control byte is the direction map (1 = input). `port_oe` is 8'hFF in output mode, the inverse of the direction map in bit-control mode, and 8'h00 otherwise.
- R9: `rd_data` returns the output register in output mode. In bit-control mode it returns the synchronized input on bits whose direction bit is 1 and the output register on the other bits. In the other modes it returns the synchronized input.
- R10: Outside bit-control mode the match condition is held false, so no pending interrupt is set.
- R11: Asserting `int_ack` for one cycle clears the pending flag. A clear wins over a set in the same cycle.
- R12: A control byte with bits [3:0] = 4'b0011 changes only the enable, which it takes from bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_data | input | 8 | Control byte |
| dat_wr | input | 1 | Output register write strobe |
| dat_wdata | input | 8 | Output register data |
| int_ack | input | 1 | Clears the pending interrupt |
| port_in | input | 8 | Port lines, asynchronous |
| port_out | output | 8 | Output register value |
| port_oe | output | 8 | Per-line output drive enable |
| rd_data | output | 8 | Read-back data |
| irq | output | 1 | Active-high interrupt request |

## Verification
The matcher is tried against a table of patterns. Each pattern pairs a mask and an active level with a line value that either just meets the condition or just misses it. In this way the table tells AND apart from OR and high level apart from low level. It also tells monitored lines apart from masked lines. An empty AND mask, a full mask and a single-line mask show that the edge cases of the combining function are handled. Directed sequences then set up a pending interrupt while the enable is off, and check that it shows on `irq` once the enable is turned on. They also show that a re-armed pattern which is still true does not fire again, and that a byte shaped like a command is taken as the mask. The read-back is tried in all four port modes with a mixed direction map.

// File: rtl/port_match_irq.sv
module port_match_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_data,
  input  logic       dat_wr,
  input  logic [7:0] dat_wdata,
  input  logic       int_ack,
  input  logic [7:0] port_in,
  output logic [7:0] port_out,
  output logic [7:0] port_oe,
  output logic [7:0] rd_data,
  output logic       irq
);
  localparam logic [1:0] M_OUT = 2'b00;
  localparam logic [1:0] M_IN  = 2'b01;
  localparam logic [1:0] M_BIT = 2'b11;

  logic [7:0] s1, s2, out_q, dir_q, mask_q;
  logic [1:0] mode_q;
  logic       en_q, and_q, hi_q, mask_nx, dir_nx, pend_q, match_q;

  wire        is_bit = (mode_q == M_BIT);
  wire [7:0] mon    = ~mask_q;
  wire [7:0] act    = (hi_q ? s2 : ~s2) & mon;
  wire        match  = is_bit && (and_q ? ((mon != 8'h00) && (act == mon)) : (|act));

  wire cmd = ctl_wr && !mask_nx && !dir_nx;
  wire icw = cmd && (ctl_data[3:0] == 4'b0111);
  wire mcw = cmd && (ctl_data[3:0] == 4'b1111);
  wire ecw = cmd && (ctl_data[3:0] == 4'b0011);
  wire clr = int_ack || (icw && ctl_data[4]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 8'h00;
      s2 <= 8'h00;
    end else begin
      s1 <= port_in;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= M_IN;
      dir_q   <= 8'hFF;
      mask_q  <= 8'hFF;
      en_q    <= 1'b0;
      and_q   <= 1'b0;
      hi_q    <= 1'b0;
      mask_nx <= 1'b0;
      dir_nx  <= 1'b0;
    end else if (ctl_wr) begin
      if (mask_nx) begin
        mask_q  <= ctl_data;
        mask_nx <= 1'b0;
      end else if (dir_nx) begin
        dir_q  <= ctl_data;
        dir_nx <= 1'b0;
      end else if (icw) begin
        en_q    <= ctl_data[7];
        and_q   <= ctl_data[6];
        hi_q    <= ctl_data[5];
        mask_nx <= ctl_data[4];
      end else if (mcw) begin
        mode_q <= ctl_data[7:6];
        dir_nx <= (ctl_data[7:6] == M_BIT);
      end else if (ecw) begin
        en_q <= ctl_data[7];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      match_q <= 1'b0;
    end else begin
      match_q <= match;
      if (clr)                  pend_q <= 1'b0;
      else if (match && !match_q) pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      out_q <= 8'h00;
    else if (dat_wr) out_q <= dat_wdata;
  end

  assign irq      = pend_q & en_q;
  assign port_out = out_q;

  always_comb begin
    case (mode_q)
      M_OUT:   begin port_oe = 8'hFF;  rd_data = out_q; end
      M_BIT:   begin port_oe = ~dir_q; rd_data = (s2 & dir_q) | (out_q & ~dir_q); end
      default: begin port_oe = 8'h00;  rd_data = s2; end
    endcase
  end
endmodule

// File: rtl/port_match_irq_chk.sv
module port_match_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_wr,
  input logic [7:0] ctl_data,
  input logic       int_ack,
  input logic       irq,
  input logic       en_q,
  input logic       pend_q,
  input logic       mask_nx,
  input logic       dir_nx,
  input logic [7:0] mask_q,
  input logic [1:0] mode_q
);
  p_irq_needs_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> en_q);

  p_mask_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && mask_nx) |=> (mask_q == $past(ctl_data)));

  p_icw_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !mask_nx && !dir_nx && ctl_data[3:0] == 4'b0111 && ctl_data[4]) |=> !pend_q);

  p_ack_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |=> !pend_q);

  p_bitmode_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> ($past(mode_q) == 2'b11));

  p_enable_word_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !mask_nx && !dir_nx && ctl_data[3:0] == 4'b0011) |=> (en_q == $past(ctl_data[7])));
endmodule

bind port_match_irq port_match_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
  .int_ack(int_ack), .irq(irq), .en_q(en_q), .pend_q(pend_q),
  .mask_nx(mask_nx), .dir_nx(dir_nx), .mask_q(mask_q), .mode_q(mode_q)
);

// File: tb/port_match_irq_tb.sv
module port_match_irq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_data = 8'h00;
  logic       dat_wr = 1'b0;
  logic [7:0] dat_wdata = 8'h00;
  logic       int_ack = 1'b0;
  logic [7:0] port_in = 8'h00;
  logic [7:0] port_out, port_oe, rd_data;
  logic       irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  port_match_irq u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
    .dat_wr(dat_wr), .dat_wdata(dat_wdata), .int_ack(int_ack),
    .port_in(port_in), .port_out(port_out), .port_oe(port_oe),
    .rd_data(rd_data), .irq(irq)
  );

  // {and, high, mask[7:0], pattern[7:0], expected irq}
  localparam logic [18:0] VEC [12] = '{
    {1'b0, 1'b1, 8'hF0, 8'h01, 1'b1},
    {1'b0, 1'b1, 8'hF0, 8'h10, 1'b0},
    {1'b1, 1'b1, 8'hF0, 8'h0F, 1'b1},
    {1'b1, 1'b1, 8'hF0, 8'h07, 1'b0},
    {1'b0, 1'b0, 8'h00, 8'hFF, 1'b0},
    {1'b0, 1'b0, 8'h00, 8'hFE, 1'b1},
    {1'b1, 1'b0, 8'h0F, 8'h0F, 1'b1},
    {1'b1, 1'b0, 8'h0F, 8'h1F, 1'b0},
    {1'b1, 1'b1, 8'hFF, 8'hFF, 1'b0},
    {1'b0, 1'b1, 8'hFF, 8'hFF, 1'b0},
    {1'b1, 1'b1, 8'h00, 8'hFF, 1'b1},
    {1'b0, 1'b1, 8'h7F, 8'h80, 1'b1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ctl(input logic [7:0] b);
    @(negedge clk); ctl_wr = 1'b1; ctl_data = b;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(1);
    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 oe", port_oe, 8'h00);
    chk("R1 out", port_out, 8'h00);

    // R4 R5 R7 pattern table
    foreach (VEC[i]) begin
      ctl(8'h4F);
      ctl({1'b1, VEC[i][18], VEC[i][17], 1'b1, 4'b0111});
      ctl(VEC[i][16:9]);
      port_in = VEC[i][8:1];
      wait_clk(3);
      ctl(8'hCF);
      ctl(8'hFF);
      wait_clk(4);
      chk($sformatf("R4/R5/R7 vec%0d irq", i), {7'd0, irq}, {7'd0, VEC[i][0]});
    end

    // R3: pending while disabled, then enable
    ctl(8'h4F);
    port_in = 8'h00;
    ctl(8'h37); ctl(8'hF0);
    ctl(8'hCF); ctl(8'hFF);
    wait_clk(3);
    port_in = 8'h01;
    wait_clk(4);
    chk("R2 disabled irq", {7'd0, irq}, 8'h00);
    ctl(8'hA7);
    chk("R3 enable shows pending", {7'd0, irq}, 8'h01);
    ctl(8'h27);
    chk("R2 disable hides", {7'd0, irq}, 8'h00);
    ctl(8'h83);
    chk("R12 enable word", {7'd0, irq}, 8'h01);
    ctl(8'h03);
    chk("R12 disable word", {7'd0, irq}, 8'h00);
    ctl(8'h83);

    // R6: clear with bit4, re-armed still-true pattern does not fire again
    ctl(8'hB7); ctl(8'hF0);
    wait_clk(4);
    chk("R6 clear no refire", {7'd0, irq}, 8'h00);

    // R11: ack clears
    port_in = 8'h00; wait_clk(4);
    port_in = 8'h01; wait_clk(4);
    chk("R7 retrigger", {7'd0, irq}, 8'h01);
    @(negedge clk); int_ack = 1'b1;
    @(negedge clk); int_ack = 1'b0;
    chk("R11 ack clears", {7'd0, irq}, 8'h00);

    // R10: no set outside bit mode
    ctl(8'h4F);
    port_in = 8'h00; wait_clk(4);
    port_in = 8'h01; wait_clk(4);
    chk("R10 input mode no irq", {7'd0, irq}, 8'h00);

    // R8 R9 read-back and drive enables
    @(negedge clk); dat_wr = 1'b1; dat_wdata = 8'hA5;
    @(negedge clk); dat_wr = 1'b0;
    port_in = 8'h3C;
    ctl(8'h27);
    ctl(8'hCF); ctl(8'h0F);
    wait_clk(3);
    chk("R8 bit oe", port_oe, 8'hF0);
    chk("R9 bit merge", rd_data, 8'hAC);
    ctl(8'h0F);
    chk("R8 out oe", port_oe, 8'hFF);
    chk("R9 out read", rd_data, 8'hA5);
    chk("R8 port_out", port_out, 8'hA5);
    ctl(8'h8F);
    chk("R8 bidir oe", port_oe, 8'h00);
    chk("R9 bidir read", rd_data, 8'h3C);
    ctl(8'h4F);
    chk("R9 in read", rd_data, 8'h3C);

    // R6: byte after bit4 word is mask even if shaped like mode word
    ctl(8'h0F);
    ctl(8'h17);
    ctl(8'h4F);
    chk("R6 mask not mode", port_oe, 8'hFF);

    finish_run();
  end
endmodule